// File: doc/BRIEF.md
# Startup Beat-Count Trim Calibrator

This block runs once after power-up and steers a beat-frequency random source into a usable operating point. A downstream beat counter reports a count of slow-oscillator cycles each time the two free-running oscillators slip by one full cycle. Each report comes with a one-cycle valid strobe. The calibrator averages a few reports and checks whether the average lies in an inclusive window (200 to 500 by default). If it does not, the calibrator moves one of two digital trim codes by a single step, waits for the oscillators to settle, and measures again.

Each trim code drives a capacitor bank, and more capacitance slows the oscillator it loads. Loading the fast oscillator, or unloading the slow one, narrows the frequency gap and so raises the count. The opposite moves lower it. The search ends in one of two terminal states. DONE holds the codes frozen and raises the done flag. FAIL is entered when the average is still outside the window and neither code can move in the needed direction.

The states and their transitions are as follows:
- RESET always goes to SETTLE.
- SETTLE discards a fixed number of strobed counts and then goes to MEASURE.
- MEASURE accumulates a fixed number of strobed counts and then goes to DECIDE.
- DECIDE goes to DONE when the average is inside the window, to ADJUST when a trim step is possible, and otherwise to FAIL.
- ADJUST applies one trim step and returns to SETTLE.
- DONE and FAIL are never left until reset.

Top module: `trim_calibrator`

## Requirements
- R1: While reset is asserted and straight after it, both trim codes equal their initial values (0 by default) and both the done and the fail flag are low.
- R2: After reset and after every trim step, the first SETTLE_BEATS (default 2) strobed counts are discarded and have no effect on any decision.
- R3: The next four strobed counts are summed, and the sum is divided by four with truncation. An average of 200 to 500 inclusive leads to DONE, with both trim codes unchanged.
- R4: An average below the low limit, with the fast code below its all-ones maximum, increments the fast code by one and leaves the slow code unchanged.
- R5: An average below the low limit, with the fast code at its maximum and the slow code above zero, decrements the slow code by one. The slow code never drops while the fast code is below its maximum.
- R6: An average above the high limit, with the slow code below its maximum, increments the slow code by one and leaves the fast code unchanged.
- R7: An average above the high limit, with the slow code at its maximum and the fast code above zero, decrements the fast code by one. The fast code never drops while the slow code is below its maximum.
- R8: An out-of-window average that no trim step can correct asserts the fail flag and leaves both codes unchanged. Done and fail are never high together.
- R9: Once done or fail is high, it stays high until reset, and further strobed counts change neither trim code.
- R10: Each adjustment changes exactly one trim code by exactly one step, and two consecutive cycles never both carry a code change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the calibration |
| beat_vld | input | 1 | One-cycle strobe marking a new beat count |
| beat_cnt | input | CNT_W | Beat count, read only when beat_vld is high |
| trim_fast | output | TRIM_W | Capacitor trim code for the fast oscillator |
| trim_slow | output | TRIM_W | Capacitor trim code for the slow oscillator |
| cal_done | output | 1 | High once the averaged count sits in the window |
| cal_fail | output | 1 | High once the window cannot be reached |

## Verification
The properties assume that beat_vld is a clean single-cycle strobe. They also assume that the beat counter reports at a rate slow enough for each decision and step to finish before the next strobe. The stimulus meets both assumptions: every count is a one-cycle pulse followed by at least three idle cycles, and each round is followed by several quiet cycles before the next round starts. The rounds deliberately place out-of-window values in the settling slots. Rounds also push each code to both ends of its range, so the fallback steps and the fail path are reached from both directions.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [2:0] {
        ST_RESET   = 3'd0,
        ST_SETTLE  = 3'd1,
        ST_MEASURE = 3'd2,
        ST_DECIDE  = 3'd3,
        ST_ADJUST  = 3'd4,
        ST_DONE    = 3'd5,
        ST_FAIL    = 3'd6
    } cal_state_t;

endpackage

// File: rtl/beat_averager.sv
module beat_averager #(
    parameter int CNT_W    = 10,
    parameter int AVG_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] avg,
    output logic             last
);
    localparam int SUM_W = CNT_W + AVG_LOG2;

    logic [SUM_W-1:0]    sum_q;
    logic [AVG_LOG2-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            idx_q <= '0;
        end else if (clr) begin
            sum_q <= '0;
            idx_q <= '0;
        end else if (take) begin
            sum_q <= sum_q + SUM_W'(cnt);
            idx_q <= idx_q + 1'b1;
        end
    end

    // the final sample of a batch is the one taken with the index all ones
    assign last = take && (idx_q == '1);
    assign avg  = sum_q[SUM_W-1:AVG_LOG2];

endmodule

// File: rtl/trim_stepper.sv
module trim_stepper #(
    parameter int TRIM_W = 4
) (
    input  logic              raise,
    input  logic [TRIM_W-1:0] fast_cur,
    input  logic [TRIM_W-1:0] slow_cur,
    output logic [TRIM_W-1:0] fast_nxt,
    output logic [TRIM_W-1:0] slow_nxt,
    output logic              can_step
);
    localparam logic [TRIM_W-1:0] CODE_MAX = '1;

    always_comb begin
        fast_nxt = fast_cur;
        slow_nxt = slow_cur;
        can_step = 1'b1;
        if (raise) begin
            // raise the count: load the fast side, else unload the slow side
            if (fast_cur != CODE_MAX)  fast_nxt = fast_cur + 1'b1;
            else if (slow_cur != '0)   slow_nxt = slow_cur - 1'b1;
            else                       can_step = 1'b0;
        end else begin
            // lower the count: load the slow side, else unload the fast side
            if (slow_cur != CODE_MAX)  slow_nxt = slow_cur + 1'b1;
            else if (fast_cur != '0)   fast_nxt = fast_cur - 1'b1;
            else                       can_step = 1'b0;
        end
    end

endmodule

// File: rtl/trim_calibrator.sv
module trim_calibrator
    import cal_pkg::*;
#(
    parameter int CNT_W        = 10,
    parameter int TRIM_W       = 4,
    parameter int LOW_LIMIT    = 200,
    parameter int HIGH_LIMIT   = 500,
    parameter int SETTLE_BEATS = 2,
    parameter int AVG_LOG2     = 2,
    parameter int INIT_FAST    = 0,
    parameter int INIT_SLOW    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_vld,
    input  logic [CNT_W-1:0]  beat_cnt,
    output logic [TRIM_W-1:0] trim_fast,
    output logic [TRIM_W-1:0] trim_slow,
    output logic              cal_done,
    output logic              cal_fail
);
    localparam int               SET_W   = $clog2(SETTLE_BEATS + 1);
    localparam logic [SET_W-1:0] SET_END = SET_W'(SETTLE_BEATS - 1);
    localparam logic [CNT_W-1:0] WIN_LO  = CNT_W'(LOW_LIMIT);
    localparam logic [CNT_W-1:0] WIN_HI  = CNT_W'(HIGH_LIMIT);

    cal_state_t        state_q, state_nxt;
    logic [SET_W-1:0]  settle_q;
    logic [CNT_W-1:0]  avg;
    logic              batch_last;
    logic              settle_last;
    logic              in_window;
    logic              want_raise;
    logic [TRIM_W-1:0] fast_step, slow_step;
    logic              can_step;

    beat_averager #(.CNT_W(CNT_W), .AVG_LOG2(AVG_LOG2)) u_avg (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == ST_SETTLE),
        .take  (beat_vld && (state_q == ST_MEASURE)),
        .cnt   (beat_cnt),
        .avg   (avg),
        .last  (batch_last)
    );

    trim_stepper #(.TRIM_W(TRIM_W)) u_step (
        .raise    (want_raise),
        .fast_cur (trim_fast),
        .slow_cur (trim_slow),
        .fast_nxt (fast_step),
        .slow_nxt (slow_step),
        .can_step (can_step)
    );

    assign in_window   = (avg >= WIN_LO) && (avg <= WIN_HI);
    assign want_raise  = (avg < WIN_LO);
    assign settle_last = beat_vld && (settle_q == SET_END);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_RESET:   state_nxt = ST_SETTLE;
            ST_SETTLE:  if (settle_last) state_nxt = ST_MEASURE;
            ST_MEASURE: if (batch_last)  state_nxt = ST_DECIDE;
            ST_DECIDE: begin
                if (in_window)     state_nxt = ST_DONE;
                else if (can_step) state_nxt = ST_ADJUST;
                else               state_nxt = ST_FAIL;
            end
            ST_ADJUST:  state_nxt = ST_SETTLE;
            ST_DONE:    state_nxt = ST_DONE;
            ST_FAIL:    state_nxt = ST_FAIL;
            default:    state_nxt = ST_RESET;
        endcase
    end

    // settle beat counter and trim code registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q  <= '0;
            trim_fast <= TRIM_W'(INIT_FAST);
            trim_slow <= TRIM_W'(INIT_SLOW);
        end else begin
            if (state_q != ST_SETTLE)   settle_q <= '0;
            else if (beat_vld)          settle_q <= settle_q + 1'b1;
            if (state_q == ST_ADJUST) begin
                trim_fast <= fast_step;
                trim_slow <= slow_step;
            end
        end
    end

    // flag outputs
    always_comb begin
        cal_done = (state_q == ST_DONE);
        cal_fail = (state_q == ST_FAIL);
    end

endmodule

// File: rtl/trim_calibrator_chk.sv
module trim_calibrator_chk #(
    parameter int TRIM_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TRIM_W-1:0] trim_fast,
    input logic [TRIM_W-1:0] trim_slow,
    input logic              cal_done,
    input logic              cal_fail
);
    localparam logic [TRIM_W-1:0] CODE_MAX = '1;

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_done && cal_fail));

    a_r9_done_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> (cal_done && $stable(trim_fast) && $stable(trim_slow)));

    a_r9_fail_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cal_fail |=> (cal_fail && $stable(trim_fast) && $stable(trim_slow)));

    a_r10_single_code_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({trim_fast, trim_slow}) |-> ($stable(trim_fast) || $stable(trim_slow)));

    a_r10_fast_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(trim_fast) |->
            ((trim_fast == $past(trim_fast) + 1'b1) || (trim_fast == $past(trim_fast) - 1'b1)));

    a_r10_slow_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(trim_slow) |->
            ((trim_slow == $past(trim_slow) + 1'b1) || (trim_slow == $past(trim_slow) - 1'b1)));

    a_r10_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({trim_fast, trim_slow}) |=> $stable({trim_fast, trim_slow}));

    a_r5_slow_unload_at_fast_max: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_slow < $past(trim_slow)) |-> (trim_fast == CODE_MAX));

    a_r7_fast_unload_at_slow_max: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_fast < $past(trim_fast)) |-> (trim_slow == CODE_MAX));

endmodule

bind trim_calibrator trim_calibrator_chk #(.TRIM_W(TRIM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trim_fast (trim_fast),
    .trim_slow (trim_slow),
    .cal_done  (cal_done),
    .cal_fail  (cal_fail)
);

// File: tb/trim_calibrator_tb.sv
`timescale 1ns/1ps
module trim_calibrator_tb;

    localparam int CNT_W  = 10;
    localparam int TRIM_W = 4;
    localparam int NROW   = 5;

    // each row: four measured counts, then expected fast code, slow code, done
    localparam int unsigned ROW_CNT [NROW][4] = '{
        '{100, 100, 100, 100},   // avg 100 -> R4 fast +1
        '{600, 600, 600, 600},   // avg 600 -> R6 slow +1
        '{199, 199, 199, 202},   // avg 199 (truncated) -> R4
        '{501, 501, 501, 503},   // avg 501 -> R6
        '{200, 200, 200, 203}    // avg 200 -> R3 done
    };
    localparam int unsigned ROW_FAST [NROW] = '{1, 1, 2, 2, 2};
    localparam int unsigned ROW_SLOW [NROW] = '{0, 1, 1, 2, 2};
    localparam int unsigned ROW_DONE [NROW] = '{0, 0, 0, 0, 1};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              beat_vld = 1'b0;
    logic [CNT_W-1:0]  beat_cnt = '0;
    logic [TRIM_W-1:0] trim_fast, trim_slow;
    logic              cal_done, cal_fail;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    trim_calibrator u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_vld  (beat_vld),
        .beat_cnt  (beat_cnt),
        .trim_fast (trim_fast),
        .trim_slow (trim_slow),
        .cal_done  (cal_done),
        .cal_fail  (cal_fail)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input int f, input int s,
                             input int d, input int x);
        check({req, " fast"}, int'(trim_fast), f);
        check({req, " slow"}, int'(trim_slow), s);
        check({req, " done"}, int'(cal_done), d);
        check({req, " fail"}, int'(cal_fail), x);
    endtask

    task automatic pulse(input int v);
        @(negedge clk);
        beat_vld = 1'b1;
        beat_cnt = CNT_W'(v);
        @(negedge clk);
        beat_vld = 1'b0;
        beat_cnt = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // two settle beats carrying junk (R2), then four measured beats
    task automatic round(input int c0, input int c1, input int c2, input int c3);
        pulse(0);
        pulse(1000);
        pulse(c0);
        pulse(c1);
        pulse(c2);
        pulse(c3);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1 in reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset", 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!ended) begin
            ended = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // table walk: R2 junk settle beats, R3 window, R4/R6 steps, truncation
        for (int r = 0; r < NROW; r++) begin
            round(int'(ROW_CNT[r][0]), int'(ROW_CNT[r][1]),
                  int'(ROW_CNT[r][2]), int'(ROW_CNT[r][3]));
            check_all($sformatf("R3/R4/R6 row %0d", r), int'(ROW_FAST[r]),
                      int'(ROW_SLOW[r]), int'(ROW_DONE[r]), 0);
        end
        // R9: after done, further rounds change nothing
        round(10, 10, 10, 10);
        round(900, 900, 900, 900);
        check_all("R9 done frozen", 2, 2, 1, 0);

        // R3 upper edge: average exactly 500
        do_reset();
        round(500, 500, 500, 503);
        check_all("R3 upper edge", 0, 0, 1, 0);

        // R5 and R8 from the low side
        do_reset();
        round(600, 600, 600, 600);
        check_all("R6 first lower", 0, 1, 0, 0);
        for (int i = 1; i <= 15; i++) begin
            round(100, 100, 100, 100);
            check("R4 fast climb", int'(trim_fast), i);
        end
        check_all("R4 fast at max", 15, 1, 0, 0);
        round(100, 100, 100, 100);
        check_all("R5 slow unload", 15, 0, 0, 0);
        round(100, 100, 100, 100);
        check_all("R8 fail low side", 15, 0, 0, 1);
        round(300, 300, 300, 300);
        check_all("R9 fail frozen", 15, 0, 0, 1);

        // R7 and R8 from the high side
        do_reset();
        round(100, 100, 100, 100);
        check_all("R4 first raise", 1, 0, 0, 0);
        for (int i = 1; i <= 15; i++) begin
            round(700, 700, 700, 700);
            check("R6 slow climb", int'(trim_slow), i);
        end
        round(700, 700, 700, 700);
        check_all("R7 fast unload", 0, 15, 0, 0);
        round(700, 700, 700, 700);
        check_all("R8 fail high side", 0, 15, 0, 1);

        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule